// File: doc/BRIEF.md
# Interrupt Priority and Reset Sequencer

This block sits beside the exception logic of a processor core. It watches a 3-bit interrupt priority level and the interrupt mask field of the status register. It raises a request, tagged with the level to be serviced, toward the exception logic. Once that request is acknowledged, it asks for the mask to be raised to the serviced level. The top level (7) acts as a non-maskable input: entering it latches a request that the mask cannot block.

After reset the block first forces the processor into its start-up mode: supervisor on, master state off, tracing off, mask at 7. It then issues two 32-bit reads over a simple request/acknowledge port. The first loads the stack pointer and the second loads the program counter. It holds instruction fetch off until both reads have completed. A halt pulse freezes the block until the next reset.

Top module: `irq_rst_seq`

## Requirements
- R1: While reset is held, and until the first clock edge after it is released, `mask_wr_o`=1, `mask_o`=7, `mode_force_o`=1 (set supervisor, clear master state and both trace bits) and `busy_o`=1. From the next cycle on, `mask_wr_o` is 0.
- R2: The reset sequence reads address `VEC_BASE` (0 by default) first and stores the data in `sp_o`. It then reads `VEC_BASE`+4 and stores the data in `pc_o`. Each `rd_req_o` stays high with a stable `rd_addr_o` until `rd_ack_i` is seen.
- R3: `busy_o` stays 1 and `fetch_en_o` stays 0 until the second read is acknowledged. In the cycle after that acknowledge, `busy_o`=0, `fetch_en_o`=1 and `rd_req_o`=0.
- R4: A level from 1 to 6 on `ipl_i` raises `irq_req_o` in the same cycle, with `irq_lvl_o` equal to that level, only when it is greater than the mask field `sr_i[10:8]`. A level equal to or below the mask raises nothing.
- R5: A change of `ipl_i` from any value below 7 to 7 latches a level-7 request whatever the mask. `irq_req_o`=1 with `irq_lvl_o`=7 from the cycle after the change.
- R6: A latched level-7 request stays raised until it is acknowledged, even after `ipl_i` falls below 7. The acknowledge clears it.
- R7: Level 7 held steady, with no pending latch, requests like a normal level: it is raised only when the mask is below 7.
- R8: In the cycle after `irq_req_o`=1 and `irq_ack_i`=1, `mask_wr_o` pulses for one cycle with `mask_o` equal to the acknowledged level and `mode_force_o`=0.
- R9: A `halt_i` pulse sets `halted_o` from the next cycle. While `halted_o` is set, `fetch_en_o`, `irq_req_o` and `rd_req_o` are 0, and a read acknowledge has no effect on `sp_o`. Only reset clears `halted_o`.
- R10: Reset clears `halted_o`, clears `sp_o` and `pc_o` to 0, and restarts the vector reads from the first address.
- R11: No interrupt request is raised while `busy_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ipl_i | input | 3 | Incoming interrupt priority level |
| sr_i | input | 16 | Status register; mask field in bits 10..8 |
| irq_ack_i | input | 1 | Exception logic accepts the current request |
| halt_i | input | 1 | Halt pulse |
| rd_ack_i | input | 1 | Read data valid |
| rd_data_i | input | 32 | Read data |
| irq_req_o | output | 1 | Interrupt request |
| irq_lvl_o | output | 3 | Level of the request |
| mask_wr_o | output | 1 | Write `mask_o` into the status mask field |
| mask_o | output | 3 | New mask value |
| mode_force_o | output | 1 | Force supervisor, clear master state and trace |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | 32 | Read address |
| sp_o | output | 32 | Loaded stack pointer |
| pc_o | output | 32 | Loaded program counter |
| busy_o | output | 1 | Reset sequence in progress |
| fetch_en_o | output | 1 | Instruction fetch released |
| halted_o | output | 1 | Halted stop state |

## Verification
A level request depends only on the current inputs, so it is checked one nanosecond after the inputs change, before the next clock edge. A level-7 entry passes through one latch, so its request is checked on the falling edge after the next rising edge, and the bench also confirms that the request is absent before that edge. The mask-update pulse after an acknowledge, the halted state after a halt pulse, and the release of fetch after the second read each come from one register stage. They are sampled at the first falling edge after the rising edge that captured the stimulus, and the bench checks again on the following edge where a pulse must have ended.

// File: rtl/irq_rst_pkg.sv
`timescale 1ns/1ps
package irq_rst_pkg;
  typedef enum logic [1:0] {
    SEQ_INIT = 2'd0,
    SEQ_SP   = 2'd1,
    SEQ_PC   = 2'd2,
    SEQ_RUN  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/irq_prio_unit.sv
`timescale 1ns/1ps
module irq_prio_unit #(
  parameter int LVL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [LVL_W-1:0] ipl_i,
  input  logic [LVL_W-1:0] mask_i,
  input  logic             ack_i,
  output logic             req_o,
  output logic [LVL_W-1:0] lvl_o,
  output logic             ack_stb_o,
  output logic [LVL_W-1:0] ack_lvl_o
);
  localparam logic [LVL_W-1:0] NMI_LVL = '1;

  logic [LVL_W-1:0] ipl_q;
  logic             nmi_pend_q;
  logic             ack_stb_q;
  logic [LVL_W-1:0] ack_lvl_q;
  logic             nmi_edge;
  logic             lvl_hit;
  logic             take;

  assign nmi_edge = (ipl_i == NMI_LVL) && (ipl_q != NMI_LVL);
  assign lvl_hit  = ipl_i > mask_i;
  assign req_o    = en_i && (nmi_pend_q || lvl_hit);
  assign lvl_o    = nmi_pend_q ? NMI_LVL : ipl_i;
  assign take     = req_o && ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ipl_q      <= '0;
      nmi_pend_q <= 1'b0;
      ack_stb_q  <= 1'b0;
      ack_lvl_q  <= '0;
    end else begin
      ipl_q     <= ipl_i;
      ack_stb_q <= take;
      if (take) ack_lvl_q <= lvl_o;
      // a fresh edge wins over an acknowledge in the same cycle
      if (nmi_edge) nmi_pend_q <= 1'b1;
      else if (take && (lvl_o == NMI_LVL)) nmi_pend_q <= 1'b0;
    end
  end

  assign ack_stb_o = ack_stb_q;
  assign ack_lvl_o = ack_lvl_q;

  // R5
  nmi_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_edge |=> (!en_i || (req_o && lvl_o == NMI_LVL)));

  // R6
  nmi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_pend_q && !take) |=> nmi_pend_q);

  // R8
  ack_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> (ack_stb_o && ack_lvl_o == $past(lvl_o)));
endmodule

// File: rtl/rst_vec_seq.sv
`timescale 1ns/1ps
module rst_vec_seq
  import irq_rst_pkg::*;
#(
  parameter int                DATA_W   = 32,
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              halted_i,
  input  logic              rd_ack_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              init_o,
  output logic              busy_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [DATA_W-1:0] sp_o,
  output logic [DATA_W-1:0] pc_o
);
  localparam logic [ADDR_W-1:0] STEP    = ADDR_W'(DATA_W / 8);
  localparam logic [ADDR_W-1:0] PC_ADDR = VEC_BASE + STEP;

  seq_state_e        state_q;
  logic [DATA_W-1:0] sp_q, pc_q;
  logic              got;

  assign init_o    = (state_q == SEQ_INIT);
  assign busy_o    = (state_q != SEQ_RUN);
  assign rd_req_o  = !halted_i && ((state_q == SEQ_SP) || (state_q == SEQ_PC));
  assign rd_addr_o = (state_q == SEQ_PC) ? PC_ADDR : VEC_BASE;
  assign got       = rd_req_o && rd_ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_INIT;
      sp_q    <= '0;
      pc_q    <= '0;
    end else if (!halted_i) begin
      unique case (state_q)
        SEQ_INIT: state_q <= SEQ_SP;
        SEQ_SP: if (got) begin
          sp_q    <= rd_data_i;
          state_q <= SEQ_PC;
        end
        SEQ_PC: if (got) begin
          pc_q    <= rd_data_i;
          state_q <= SEQ_RUN;
        end
        default: state_q <= SEQ_RUN;
      endcase
    end
  end

  assign sp_o = sp_q;
  assign pc_o = pc_q;

  // R2
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_ack_i) |=> (halted_i || (rd_req_o && $stable(rd_addr_o))));

  // R3
  busy_rel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(rd_ack_i && rd_req_o && rd_addr_o == PC_ADDR));

  // R2
  pc_after_sp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && rd_addr_o == VEC_BASE && rd_ack_i) |=> (halted_i || rd_addr_o == PC_ADDR));
endmodule

// File: rtl/stop_ctl.sv
`timescale 1ns/1ps
module stop_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic halt_i,
  output logic halted_o
);
  logic halted_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     halted_q <= 1'b0;
    else if (halt_i) halted_q <= 1'b1;
  end

  assign halted_o = halted_q;

  // R9
  halt_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> halted_o);

  // R9
  halt_stick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o);
endmodule

// File: rtl/irq_rst_seq.sv
`timescale 1ns/1ps
module irq_rst_seq #(
  parameter int                LVL_W    = 3,
  parameter int                SR_W     = 16,
  parameter int                MASK_LSB = 8,
  parameter int                DATA_W   = 32,
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LVL_W-1:0]  ipl_i,
  input  logic [SR_W-1:0]   sr_i,
  input  logic              irq_ack_i,
  input  logic              halt_i,
  input  logic              rd_ack_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              irq_req_o,
  output logic [LVL_W-1:0]  irq_lvl_o,
  output logic              mask_wr_o,
  output logic [LVL_W-1:0]  mask_o,
  output logic              mode_force_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [DATA_W-1:0] sp_o,
  output logic [DATA_W-1:0] pc_o,
  output logic              busy_o,
  output logic              fetch_en_o,
  output logic              halted_o
);
  localparam logic [LVL_W-1:0] MASK_TOP = '1;

  logic [LVL_W-1:0] cur_mask;
  logic             unused_sr;
  logic             init;
  logic             ack_stb;
  logic [LVL_W-1:0] ack_lvl;

  assign cur_mask  = sr_i[MASK_LSB +: LVL_W];
  assign unused_sr = ^{sr_i[SR_W-1:MASK_LSB+LVL_W], sr_i[MASK_LSB-1:0]};

  stop_ctl u_stop (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .halt_i   (halt_i),
    .halted_o (halted_o)
  );

  rst_vec_seq #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .VEC_BASE (VEC_BASE)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .halted_i  (halted_o),
    .rd_ack_i  (rd_ack_i),
    .rd_data_i (rd_data_i),
    .init_o    (init),
    .busy_o    (busy_o),
    .rd_req_o  (rd_req_o),
    .rd_addr_o (rd_addr_o),
    .sp_o      (sp_o),
    .pc_o      (pc_o)
  );

  assign fetch_en_o = !busy_o && !halted_o;

  irq_prio_unit #(
    .LVL_W (LVL_W)
  ) u_prio (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (fetch_en_o),
    .ipl_i     (ipl_i),
    .mask_i    (cur_mask),
    .ack_i     (irq_ack_i),
    .req_o     (irq_req_o),
    .lvl_o     (irq_lvl_o),
    .ack_stb_o (ack_stb),
    .ack_lvl_o (ack_lvl)
  );

  assign mode_force_o = init;
  assign mask_wr_o    = init || ack_stb;
  assign mask_o       = init ? MASK_TOP : ack_lvl;

  // R11
  no_irq_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !irq_req_o);

  // R9
  halt_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> (!irq_req_o && !rd_req_o && !fetch_en_o));
endmodule

// File: tb/irq_rst_seq_tb.sv
`timescale 1ns/1ps
module irq_rst_seq_tb;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic [2:0]  ipl;
  logic [15:0] sr;
  logic        irq_ack, halt, rd_ack;
  logic [31:0] rd_data;
  logic        irq_req, mask_wr, mode_force, rd_req, busy, fetch_en, halted;
  logic [2:0]  irq_lvl, mask;
  logic [31:0] rd_addr, sp, pc;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #2.5 clk = ~clk;

  irq_rst_seq u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .ipl_i(ipl), .sr_i(sr),
    .irq_ack_i(irq_ack), .halt_i(halt), .rd_ack_i(rd_ack), .rd_data_i(rd_data),
    .irq_req_o(irq_req), .irq_lvl_o(irq_lvl), .mask_wr_o(mask_wr), .mask_o(mask),
    .mode_force_o(mode_force), .rd_req_o(rd_req), .rd_addr_o(rd_addr),
    .sp_o(sp), .pc_o(pc), .busy_o(busy), .fetch_en_o(fetch_en), .halted_o(halted)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp<=20000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic apply_reset();
    rst_ni = 1'b0; ipl = 3'd0; sr = 16'h2700; irq_ack = 1'b0; halt = 1'b0;
    rd_ack = 1'b0; rd_data = '0;
    repeat (3) @(negedge clk);
    chk("R1 mask_wr in reset", 32'(mask_wr), 1);
    chk("R1 mask in reset", 32'(mask), 7);
    chk("R1 force in reset", 32'(mode_force), 1);
    chk("R1 busy in reset", 32'(busy), 1);
    chk("R10 halted clear", 32'(halted), 0);
    chk("R10 sp clear", sp, 0);
    chk("R10 pc clear", pc, 0);
    rst_ni = 1'b1;
    #1;
    chk("R1 force after release", 32'(mode_force), 1);
    @(negedge clk);
    chk("R1 mask_wr ends", 32'(mask_wr), 0);
    chk("R1 force ends", 32'(mode_force), 0);
    chk("R10 first read req", 32'(rd_req), 1);
    chk("R10 first read addr", rd_addr, 32'h0);
  endtask

  task automatic vec_fetch(input logic [31:0] sp_v, input logic [31:0] pc_v);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk("R2 sp req held", 32'(rd_req), 1);
      chk("R2 sp addr", rd_addr, 32'h0);
    end
    rd_ack = 1'b1; rd_data = sp_v;
    @(negedge clk);
    rd_ack = 1'b0; rd_data = '0;
    chk("R2 sp loaded", sp, sp_v);
    chk("R2 pc addr", rd_addr, 32'h4);
    chk("R2 pc req", 32'(rd_req), 1);
    chk("R3 busy mid", 32'(busy), 1);
    chk("R3 fetch off", 32'(fetch_en), 0);
    ipl = 3'd5; sr = 16'h2000;
    #1;
    chk("R11 no req while busy", 32'(irq_req), 0);
    @(negedge clk);
    chk("R2 pc req held", 32'(rd_req), 1);
    rd_ack = 1'b1; rd_data = pc_v;
    #1;
    chk("R3 busy until ack taken", 32'(busy), 1);
    @(negedge clk);
    rd_ack = 1'b0; rd_data = '0;
    chk("R3 busy released", 32'(busy), 0);
    chk("R3 fetch released", 32'(fetch_en), 1);
    chk("R3 no read", 32'(rd_req), 0);
    chk("R2 pc loaded", pc, pc_v);
    chk("R2 sp kept", sp, sp_v);
    chk("R4 req after release", 32'(irq_req), 1);
    chk("R4 lvl after release", 32'(irq_lvl), 5);
    ipl = 3'd0; sr = 16'h2700;
  endtask

  task automatic level_test();
    @(negedge clk); sr = 16'h2300; ipl = 3'd3; #1;
    chk("R4 equal to mask", 32'(irq_req), 0);
    @(negedge clk); ipl = 3'd2; #1;
    chk("R4 below mask", 32'(irq_req), 0);
    @(negedge clk); ipl = 3'd4; #1;
    chk("R4 above mask req", 32'(irq_req), 1);
    chk("R4 above mask lvl", 32'(irq_lvl), 4);
    @(negedge clk); ipl = 3'd6; #1;
    chk("R4 lvl6", 32'(irq_lvl), 6);
    @(negedge clk); ipl = 3'd0; #1;
    chk("R4 drop", 32'(irq_req), 0);
  endtask

  task automatic ack_test();
    @(negedge clk); sr = 16'h2300; ipl = 3'd5; #1;
    chk("R8 req before ack", 32'(irq_req), 1);
    irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    chk("R8 mask_wr", 32'(mask_wr), 1);
    chk("R8 mask value", 32'(mask), 5);
    chk("R8 no force", 32'(mode_force), 0);
    sr = 16'h2500; #1;
    chk("R4 masked after update", 32'(irq_req), 0);
    @(negedge clk);
    chk("R8 single pulse", 32'(mask_wr), 0);
    ipl = 3'd0; sr = 16'h2700;
  endtask

  task automatic nmi_test();
    @(negedge clk); sr = 16'h2700; ipl = 3'd7; #1;
    chk("R5 not before edge", 32'(irq_req), 0);
    @(negedge clk);
    chk("R5 nmi req", 32'(irq_req), 1);
    chk("R5 nmi lvl", 32'(irq_lvl), 7);
    ipl = 3'd0;
    repeat (3) @(negedge clk);
    chk("R6 latched req", 32'(irq_req), 1);
    chk("R6 latched lvl", 32'(irq_lvl), 7);
    irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    chk("R8 nmi mask", 32'(mask), 7);
    chk("R8 nmi mask_wr", 32'(mask_wr), 1);
    chk("R6 cleared by ack", 32'(irq_req), 0);
    ipl = 3'd7;
    @(negedge clk);
    chk("R5 second edge", 32'(irq_req), 1);
    irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    chk("R7 steady masked", 32'(irq_req), 0);
    repeat (2) @(negedge clk);
    chk("R7 still masked", 32'(irq_req), 0);
    sr = 16'h2600; #1;
    chk("R7 level req", 32'(irq_req), 1);
    chk("R7 level lvl", 32'(irq_lvl), 7);
    @(negedge clk); sr = 16'h2700; ipl = 3'd0;
  endtask

  task automatic halt_test();
    @(negedge clk); sr = 16'h2000; ipl = 3'd2; #1;
    chk("R4 req pre halt", 32'(irq_req), 1);
    @(negedge clk); halt = 1'b1;
    @(negedge clk); halt = 1'b0;
    chk("R9 halted", 32'(halted), 1);
    chk("R9 fetch off", 32'(fetch_en), 0);
    chk("R9 req off", 32'(irq_req), 0);
    repeat (4) @(negedge clk);
    chk("R9 halt sticks", 32'(halted), 1);
    ipl = 3'd0; sr = 16'h2700;
  endtask

  task automatic halt_in_seq();
    halt = 1'b1;
    @(negedge clk); halt = 1'b0;
    chk("R9 read dropped", 32'(rd_req), 0);
    rd_ack = 1'b1; rd_data = 32'hDEAD_BEEF;
    @(negedge clk); rd_ack = 1'b0; rd_data = '0;
    chk("R9 ack ignored", sp, 0);
    chk("R9 busy held", 32'(busy), 1);
  endtask

  initial begin
    apply_reset();
    vec_fetch(32'h0000_8000, 32'h0000_0400);
    level_test();
    ack_test();
    nmi_test();
    halt_test();
    apply_reset();
    halt_in_seq();
    apply_reset();
    vec_fetch(32'h00FF_FFFC, 32'h1234_5678);
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule